// File: doc/BRIEF.md
# Fractional Multiply-Accumulate-Round Unit

This block is a datapath for one fixed-point signal-processing step. It multiplies two signed fractional operands and adds their product to a wide accumulator value. It then rounds the sum to the precision of the accumulator's middle word and returns the new accumulator together with a set of status flags. Operands and the old accumulator value arrive with an input strobe. The rounded result and its flags appear together on an output strobe a fixed number of cycles later, one or two depending on a parameter.

The accumulator is split into three fields. The top field holds guard bits (bits 55:48 by default). The middle field holds the main word (bits 47:24). The bottom field holds the low word (bits 23:0). Operands are 24-bit two's-complement fractions, and their product is aligned to the binary point of the middle word. After the sum is rounded, the low word always reads zero. The guard field allows values outside the range [-1, +1) without saturation, and the flags report when this happens. A sticky limit bit records that an overflow occurred at some point. It stays set until a dedicated clear input is asserted. Reset does not clear it.

Top module: `frac_mac_round`

## Requirements
- R1: The result equals the old accumulator plus twice the signed product of the operands, with the product sign-extended across the guard field before rounding. The case -1.0 times -1.0 with a zero accumulator gives 0x00_800000_000000 (+1.0), with no saturation.
- R2: After rounding, the low word of acc_out is zero. The middle and guard fields together are incremented when the discarded low word is greater than half an LSB (0x800000 at default width), and are left unchanged when it is less.
- R3: A low word of exactly half an LSB rounds to even. An even middle word stays the same, and an odd middle word is incremented.
- R4: Operands 0x123456 and 0x123456 with accumulator 0x00_100000_000000 give 0x00_1296CE_000000.
- R5: sts[3] (negative) equals the top bit of acc_out. sts[2] (zero) is set exactly when every bit of acc_out is zero.
- R6: sts[1] (overflow) is set when the full-width signed addition overflows, or when the rounding increment carries from the largest positive value into the sign bit. In both cases the result wraps in two's complement.
- R7: sts[0] (limit) is set in any result cycle where overflow is set, and it then stays set. A lim_clr pulse clears it unless a result with overflow arrives in the same cycle, in which case it stays set. Reset leaves it unchanged.
- R8: sts[5] (extension in use) is set when the guard bits and the top bit of the middle word, taken together, are not all equal.
- R9: sts[4] (unnormalized) is set when the top two bits of the middle word (bits 47 and 46 at default width) are equal.
- R10: out_valid pulses for one cycle, PIPE cycles after each cycle in which in_valid is high. acc_out and sts[5:1] change only in a cycle where out_valid is high. Operand and accumulator inputs have no effect while in_valid is low.
- R11: A synchronous reset clears acc_out, out_valid and sts[5:1].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lim_clr | input | 1 | Clears the sticky limit flag |
| in_valid | input | 1 | Input strobe: operands and accumulator are valid |
| op_a | input | OP_W (24) | Signed fractional multiplicand |
| op_b | input | OP_W (24) | Signed fractional multiplier |
| acc_in | input | EXT_W+2*OP_W (56) | Old accumulator value |
| out_valid | output | 1 | Result strobe |
| acc_out | output | EXT_W+2*OP_W (56) | Rounded accumulator |
| sts | output | 6 | Flags {extension, unnormalized, negative, zero, overflow, limit} |

## Verification
A wrong pipeline register or a dropped valid bit shows up at out_valid and acc_out exactly PIPE cycles after the input strobe. A corrupted tie or carry decision in the rounder changes only results whose low word is at or near half an LSB. A narrow configuration is therefore swept exhaustively over both operands and a set of accumulators chosen to land on those cases. A wrong limit state lasts across results until the next clear, so it is checked after overflow, after a later result without overflow, after a clear and after a reset.

// File: rtl/fmr_pkg.sv
package fmr_pkg;

   // Per-result status, most significant first; the limit bit sits apart
   typedef struct packed {
      logic ext_use;
      logic unnorm;
      logic neg;
      logic zero;
      logic ovf;
   } fmr_stat_t;

   localparam int STAT_W = $bits(fmr_stat_t);

endpackage

// File: rtl/fmr_product.sv
module fmr_product #(
   parameter int OP_W  = 24,
   parameter int EXT_W = 8,
   parameter int PIPE  = 2,
   localparam int ACC_W = EXT_W + 2 * OP_W,
   localparam int PRD_W = 2 * OP_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [OP_W-1:0]  op_a,
   input  logic [OP_W-1:0]  op_b,
   input  logic [ACC_W-1:0] acc_in,
   output logic             p_valid,
   output logic [ACC_W-1:0] p_frac,
   output logic [ACC_W-1:0] p_acc
);

   logic signed [PRD_W-1:0] prod;
   logic        [ACC_W-1:0] frac;

   assign prod = $signed(op_a) * $signed(op_b);
   // Fractional alignment: one left shift, sign carried through the guard bits
   assign frac = {{(EXT_W-1){prod[PRD_W-1]}}, prod, 1'b0};

   generate
      if (PIPE == 2) begin : g_stage
         logic             v_q;
         logic [ACC_W-1:0] frac_q;
         logic [ACC_W-1:0] acc_q;

         always_ff @(posedge clk) begin
            if (rst) v_q <= 1'b0;
            else     v_q <= in_valid;
         end

         always_ff @(posedge clk) begin
            if (in_valid) begin
               frac_q <= frac;
               acc_q  <= acc_in;
            end
         end

         assign p_valid = v_q;
         assign p_frac  = frac_q;
         assign p_acc   = acc_q;
      end else begin : g_pass
         assign p_valid = in_valid;
         assign p_frac  = frac;
         assign p_acc   = acc_in;
      end
   endgenerate

endmodule

// File: rtl/fmr_round.sv
module fmr_round #(
   parameter int OP_W  = 24,
   parameter int EXT_W = 8,
   localparam int ACC_W = EXT_W + 2 * OP_W,
   localparam int UP_W  = EXT_W + OP_W
) (
   input  logic [ACC_W-1:0] frac,
   input  logic [ACC_W-1:0] acc,
   output logic [ACC_W-1:0] res,
   output logic             ovf
);

   localparam logic [OP_W-1:0] HALF = {1'b1, {(OP_W-1){1'b0}}};

   logic [ACC_W:0]   sum_x;
   logic [ACC_W-1:0] sum;
   logic             add_ovf;
   logic [OP_W-1:0]  low;
   logic [UP_W-1:0]  up;
   logic [UP_W-1:0]  up_r;
   logic             bump;
   logic             rnd_ovf;

   assign sum_x   = {acc[ACC_W-1], acc} + {frac[ACC_W-1], frac};
   assign sum     = sum_x[ACC_W-1:0];
   assign add_ovf = sum_x[ACC_W] ^ sum_x[ACC_W-1];

   assign low = sum[OP_W-1:0];
   assign up  = sum[ACC_W-1:OP_W];

   // Convergent: above half always bumps, exact half bumps only an odd word
   assign bump    = (low > HALF) || ((low == HALF) && up[0]);
   assign up_r    = up + UP_W'(bump);
   assign rnd_ovf = bump & ~up[UP_W-1] & up_r[UP_W-1];

   assign res = {up_r, {OP_W{1'b0}}};
   assign ovf = add_ovf | rnd_ovf;

endmodule

// File: rtl/fmr_flags.sv
module fmr_flags #(
   parameter int OP_W  = 24,
   parameter int EXT_W = 8,
   localparam int ACC_W = EXT_W + 2 * OP_W,
   localparam int MID_T = ACC_W - EXT_W - 1
) (
   input  logic [ACC_W-1:0]      res,
   input  logic                  ovf,
   output fmr_pkg::fmr_stat_t    stat
);

   logic [EXT_W:0] head;

   assign head = res[ACC_W-1:MID_T];

   always_comb begin
      stat.ext_use = !((&head) || (~|head));
      stat.unnorm  = (res[MID_T] == res[MID_T-1]);
      stat.neg     = res[ACC_W-1];
      stat.zero    = ~|res;
      stat.ovf     = ovf;
   end

endmodule

// File: rtl/frac_mac_round.sv
module frac_mac_round #(
   parameter int OP_W  = 24,
   parameter int EXT_W = 8,
   parameter int PIPE  = 2,
   localparam int ACC_W = EXT_W + 2 * OP_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             lim_clr,
   input  logic             in_valid,
   input  logic [OP_W-1:0]  op_a,
   input  logic [OP_W-1:0]  op_b,
   input  logic [ACC_W-1:0] acc_in,
   output logic             out_valid,
   output logic [ACC_W-1:0] acc_out,
   output logic [5:0]       sts
);

   import fmr_pkg::*;

   generate
      if (PIPE < 1 || PIPE > 2) begin : g_bad_pipe
         $error("frac_mac_round: PIPE must be 1 or 2");
      end
      if (OP_W < 2) begin : g_bad_op
         $error("frac_mac_round: OP_W must be at least 2");
      end
      if (EXT_W < 2) begin : g_bad_ext
         $error("frac_mac_round: EXT_W must be at least 2");
      end
   endgenerate

   logic             p_valid;
   logic [ACC_W-1:0] p_frac;
   logic [ACC_W-1:0] p_acc;
   logic [ACC_W-1:0] r_res;
   logic             r_ovf;
   fmr_stat_t        r_stat;

   logic             ov_q;
   logic [ACC_W-1:0] acc_q;
   fmr_stat_t        stat_q;
   logic             lim_q;

   fmr_product #(.OP_W(OP_W), .EXT_W(EXT_W), .PIPE(PIPE)) u_prod (
      .clk     (clk),
      .rst     (rst),
      .in_valid(in_valid),
      .op_a    (op_a),
      .op_b    (op_b),
      .acc_in  (acc_in),
      .p_valid (p_valid),
      .p_frac  (p_frac),
      .p_acc   (p_acc)
   );

   fmr_round #(.OP_W(OP_W), .EXT_W(EXT_W)) u_round (
      .frac(p_frac),
      .acc (p_acc),
      .res (r_res),
      .ovf (r_ovf)
   );

   fmr_flags #(.OP_W(OP_W), .EXT_W(EXT_W)) u_flags (
      .res (r_res),
      .ovf (r_ovf),
      .stat(r_stat)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ov_q   <= 1'b0;
         acc_q  <= '0;
         stat_q <= '0;
      end else begin
         ov_q <= p_valid;
         if (p_valid) begin
            acc_q  <= r_res;
            stat_q <= r_stat;
         end
      end
   end

   // Sticky limit: a new overflow wins over a clear in the same cycle
   always_ff @(posedge clk) begin
      if (p_valid && r_stat.ovf) lim_q <= 1'b1;
      else if (lim_clr)          lim_q <= 1'b0;
   end

   assign out_valid = ov_q;
   assign acc_out   = acc_q;
   assign sts       = {stat_q, lim_q};

   // ---------------- assertions ----------------
   generate
      if (PIPE == 1) begin : g_lat1
         a_r10_latency_on: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
         a_r10_latency_off: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
      end else begin : g_lat2
         a_r10_latency_on: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> ##1 out_valid);
         a_r10_latency_off: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> ##1 !out_valid);
      end
   endgenerate

   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      (!out_valid && !$past(rst)) |-> ($stable(acc_out) && $stable(sts[5:1])));

   a_r2_low_zero: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (acc_out[OP_W-1:0] == '0));

   a_r5_neg_bit: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (sts[3] == acc_out[ACC_W-1]));

   a_r7_ovf_sets_lim: assert property (@(posedge clk) disable iff (rst)
      (out_valid && sts[1]) |-> sts[0]);

   a_r7_lim_sticky: assert property (@(posedge clk) disable iff (rst)
      (sts[0] && !lim_clr) |=> sts[0]);

endmodule

// File: tb/frac_mac_round_tb.sv
module frac_mac_round_tb_top;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst, clr_s, clr_w;

   // narrow configuration for exhaustive sweeps
   localparam int SW = 5, SX = 3, SA = SX + 2 * SW;
   logic          s_v;
   logic [SW-1:0] s_a, s_b;
   logic [SA-1:0] s_acc, s_out;
   logic          s_ov;
   logic [5:0]    s_sts;

   // default-width configuration, two-stage
   localparam int WW = 24, WX = 8, WA = WX + 2 * WW;
   logic          w_v;
   logic [WW-1:0] w_a, w_b;
   logic [WA-1:0] w_acc, w_out;
   logic          w_ov;
   logic [5:0]    w_sts;

   frac_mac_round #(.OP_W(SW), .EXT_W(SX), .PIPE(1)) dut_i (
      .clk(clk), .rst(rst), .lim_clr(clr_s), .in_valid(s_v),
      .op_a(s_a), .op_b(s_b), .acc_in(s_acc),
      .out_valid(s_ov), .acc_out(s_out), .sts(s_sts));

   frac_mac_round #(.OP_W(WW), .EXT_W(WX), .PIPE(2)) dut_w (
      .clk(clk), .rst(rst), .lim_clr(clr_w), .in_valid(w_v),
      .op_a(w_a), .op_b(w_b), .acc_in(w_acc),
      .out_valid(w_ov), .acc_out(w_out), .sts(w_sts));

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;
   bit lm_s  = 0;
   bit lm_w  = 0;

   function automatic longint msk(int n);
      return (longint'(1) << n) - 1;
   endfunction

   function automatic longint sx(longint v, int n);
      return (((v >> (n - 1)) & 1) != 0) ? v - (longint'(1) << n) : v;
   endfunction

   task automatic model(input int w, input int x, input longint a, input longint b,
                        input longint acc, output longint res, output bit v);
      longint sum, sw, low, up, half;
      int aw, uw;
      bit rnd;
      aw   = x + 2 * w;
      uw   = x + w;
      sum  = sx(acc, aw) + 2 * sx(a, w) * sx(b, w);
      v    = (sum > msk(aw - 1)) || (sum < -(longint'(1) << (aw - 1)));
      sw   = sum & msk(aw);
      low  = sw & msk(w);
      up   = sw >> w;
      half = longint'(1) << (w - 1);
      rnd  = (low > half) || (low == half && up[0]);
      if (rnd && up == msk(uw - 1)) v = 1;
      res  = ((up + longint'(rnd)) & msk(uw)) << w;
   endtask

   function automatic longint flg(int w, int x, longint res, bit v);
      int aw, mt;
      longint head;
      bit e, u, n, z;
      aw   = x + 2 * w;
      mt   = aw - x - 1;
      head = (res >> mt) & msk(x + 1);
      e    = !(head == 0 || head == msk(x + 1));
      u    = (((res >> mt) & 1) == ((res >> (mt - 1)) & 1));
      n    = ((res >> (aw - 1)) & 1) != 0;
      z    = (res == 0);
      return longint'({e, u, n, z, v});
   endfunction

   task automatic check(string tag, longint got, longint exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic s_op(longint a, longint b, longint acc);
      longint res; bit v;
      @(negedge clk);
      s_a = SW'(a); s_b = SW'(b); s_acc = SA'(acc); s_v = 1'b1;
      @(negedge clk);
      s_v = 1'b0;
      model(SW, SX, a, b, acc, res, v);
      lm_s = lm_s | v;
      check("R10 narrow strobe", longint'(s_ov), 1);
      check("R1 R2 R3 R6 sweep value", longint'(s_out), res);
      check("R5 R6 R7 R8 R9 sweep flags", longint'(s_sts),
            (flg(SW, SX, res, v) << 1) | longint'(lm_s));
   endtask

   task automatic w_op(longint a, longint b, longint acc, string tag);
      longint res; bit v;
      @(negedge clk);
      w_a = WW'(a); w_b = WW'(b); w_acc = WA'(acc); w_v = 1'b1;
      @(negedge clk);
      w_v = 1'b0;
      check("R10 no early strobe", longint'(w_ov), 0);
      @(negedge clk);
      check("R10 strobe after two", longint'(w_ov), 1);
      model(WW, WX, a, b, acc, res, v);
      lm_w = lm_w | v;
      check(tag, longint'(w_out), res);
      check(tag, longint'(w_sts), (flg(WW, WX, res, v) << 1) | longint'(lm_w));
   endtask

   function automatic longint acc_pick(int k);
      case (k)
         0: return 0;
         1: return 'h0FFF;   // largest positive
         2: return 'h1000;   // most negative
         3: return 'h0010;   // exact half, even middle
         4: return 'h0030;   // exact half, odd middle
         5: return 'h0011;
         6: return 'h0F00;
         7: return 'h1F1F;
         default: return (longint'(k) * 977 + 13) & msk(SA);
      endcase
   endfunction

   initial begin
      longint keep_acc, keep_sts;
      rst = 1; clr_s = 1; clr_w = 1;
      s_v = 0; s_a = '0; s_b = '0; s_acc = '0;
      w_v = 0; w_a = '0; w_b = '0; w_acc = '0;
      repeat (3) @(negedge clk);
      rst = 0; clr_s = 0; clr_w = 0;
      @(negedge clk);
      check("R11 reset value", longint'(w_out), 0);
      check("R11 reset flags", longint'(w_sts), 0);
      check("R11 reset strobe", longint'(w_ov), 0);
      check("R11 reset narrow", longint'({s_ov, s_sts, s_out}), 0);

      // R4 worked example
      w_op('h123456, 'h123456, 'h00100000000000, "R4 worked");
      check("R4 literal", longint'(w_out), 'h001296CE000000);

      // R1 -1.0 x -1.0 lands at +1.0 in the guard range, R8 extension use
      w_op('h800000, 'h800000, 0, "R1 minus one squared");
      check("R1 literal", longint'(w_out), 'h00800000000000);
      check("R8 extension set", longint'(w_sts[5]), 1);
      check("R9 normalized", longint'(w_sts[4]), 0);

      // R3 ties
      w_op(0, 0, 'h00000002800000, "R3 tie even");
      check("R3 even kept", longint'(w_out), 'h00000002000000);
      w_op(0, 0, 'h00000003800000, "R3 tie odd");
      check("R3 odd bumped", longint'(w_out), 'h00000004000000);

      // R2 either side of half
      w_op(0, 0, 'h00000002800001, "R2 above half");
      check("R2 above literal", longint'(w_out), 'h00000003000000);
      w_op(0, 0, 'h000000027FFFFF, "R2 below half");
      check("R2 below literal", longint'(w_out), 'h00000002000000);

      // R9 unnormalized
      w_op(0, 0, 'h00100000000000, "R9 small value");
      check("R9 unnormalized set", longint'(w_sts[4]), 1);

      // R5 negative, then zero
      w_op('h400000, 'hC00000, 0, "R5 negative");
      check("R5 negative literal", longint'(w_out), 'hFFE00000000000);
      check("R5 negative flag", longint'(w_sts[3]), 1);
      w_op('h400000, 'h400000, 'hFFE00000000000, "R5 zero");
      check("R5 zero flag", longint'(w_sts[2]), 1);

      // R6 addition overflow sets V and L
      w_op('h7FFFFF, 'h7FFFFF, 'h7FFFFFFF000000, "R6 add overflow");
      check("R6 overflow flag", longint'(w_sts[1]), 1);
      check("R7 limit follows", longint'(w_sts[0]), 1);

      // R7 sticky through a clean result, then cleared
      w_op(0, 0, 0, "R7 clean result");
      check("R7 overflow clear", longint'(w_sts[1]), 0);
      check("R7 limit held", longint'(w_sts[0]), 1);
      @(negedge clk); clr_w = 1;
      @(negedge clk); clr_w = 0; lm_w = 0;
      check("R7 limit cleared", longint'(w_sts[0]), 0);

      // R6 rounding carry into the sign bit
      w_op(0, 0, 'h7FFFFFFF900000, "R6 round overflow");
      check("R6 round wrap literal", longint'(w_out), 'h80000000000000);
      check("R6 round overflow flag", longint'(w_sts[1]), 1);

      // R10 hold while in_valid is low, inputs wiggling
      keep_acc = longint'(w_out); keep_sts = longint'(w_sts);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         w_a = WW'(i * 'h35A1F3); w_b = WW'(~i); w_acc = WA'(i * 'h1234567);
         check("R10 no strobe when idle", longint'(w_ov), 0);
      end
      check("R10 value held", longint'(w_out), keep_acc);
      check("R10 flags held", longint'(w_sts), keep_sts);

      // R11 reset keeps the limit bit
      @(negedge clk); rst = 1;
      @(negedge clk);
      @(negedge clk); rst = 0;
      check("R11 value after reset", longint'(w_out), 0);
      check("R11 R7 flags after reset", longint'(w_sts), 1);
      check("R11 strobe after reset", longint'(w_ov), 0);
      check("R7 narrow limit kept", longint'(s_sts[0]), longint'(lm_s));

      // exhaustive narrow sweep
      for (int k = 0; k < 16; k++)
         for (int a = 0; a < (1 << SW); a++)
            for (int b = 0; b < (1 << SW); b++)
               s_op(a, b, acc_pick(k));

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule